// File: doc/BRIEF.md
# DTMF Keypad Decode Logic

This block sits between the keypad sensing circuitry and the two tone synthesisers of a dual-tone signalling generator. Each clock it samples the active state of four row lines and four column lines, which may come from a two-line-per-key keypad, a single-contact keypad or an electronic driver. From these it decides whether the low-group (row) tone, the high-group (column) tone, both or neither should sound. It also gives each enabled synthesiser the 2-bit index of its frequency.

The block also produces a mute output and a transmitter-control enable, both driven only by whether any line is active. A dual-only input, active low, suppresses every single-tone outcome so that only full key presses reach the line. Inputs are clean synchronous levels: analog thresholds and debouncing are handled elsewhere. Every output is registered.

Top module: `dtmf_key_decode`

## Requirements
- R1: While `rst_n` is low, `row_en`, `col_en`, `row_sel`, `col_sel` and `mute` are 0 and `xmitr_oe` is 1, whatever the line inputs are.
- R2: Exactly one row line and exactly one column line active sets both `row_en` and `col_en`. Row line i gives `row_sel` = i and column line j gives `col_sel` = j, where line index k is bit k of the bus.
- R3: One row line with two or more column lines active enables only the row tone, with `row_sel` set to that row's index.
- R4: One column line with two or more row lines active enables only the column tone, with `col_sel` set to that column's index.
- R5: Two or more row lines together with two or more column lines active enable neither tone.
- R6: With no row line active, exactly one column line enables that column's tone alone, and two or more column lines enable no tone.
- R7: Any number of row lines with no column line active enables no tone.
- R8: While `dual_ok_n` is 0, every case of R3, R4 and R6 that would enable one tone enables none instead. R2 still enables both tones.
- R9: `mute` is 1 when any row or column line is active and 0 otherwise, whatever the state of `dual_ok_n`.
- R10: `xmitr_oe` is 1 (output driving high) when no line is active and 0 (output released to high impedance) when any line is active, whatever the state of `dual_ok_n`.
- R11: Outputs follow the inputs sampled at the previous rising clock edge. A select whose enable is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_act | input | 4 | Row line active flags, bit k = row k |
| col_act | input | 4 | Column line active flags, bit k = column k |
| dual_ok_n | input | 1 | 0 = dual tones only, 1 = single and dual tones allowed |
| row_en | output | 1 | Enable for the row tone generator |
| col_en | output | 1 | Enable for the column tone generator |
| row_sel | output | 2 | Row frequency index |
| col_sel | output | 2 | Column frequency index |
| mute | output | 1 | High while any line is active |
| xmitr_oe | output | 1 | 1 = transmitter-control output driven high, 0 = released |

## Verification
Every result, both the tone enables and selects and the mute and transmitter-control levels, is due exactly one rising edge after the inputs that cause it are sampled. The bench drives a new input vector on each falling edge. On the next falling edge it compares all outputs against a reference model evaluated on the vector that the intervening rising edge captured. A separate probe looks just after a new key vector is driven, before the next rising edge, and confirms that `mute` has not yet moved.

// File: rtl/dtmf_kd_pkg.sv
package dtmf_kd_pkg;

   // How many lines of one group are active
   typedef enum logic [1:0] {
      LN_NONE = 2'd0,
      LN_ONE  = 2'd1,
      LN_MANY = 2'd2
   } line_cnt_e;

   // Decoded tone request before registering
   typedef struct packed {
      logic row_en;
      logic col_en;
      logic any_key;
   } tone_req_t;

endpackage

// File: rtl/dtmf_line_scan.sv
module dtmf_line_scan
   import dtmf_kd_pkg::*;
#(
   parameter int unsigned NUM_LINES = 4,
   localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic [NUM_LINES-1:0] lines,
   output line_cnt_e            cnt,
   output logic [IDX_W-1:0]     idx
);

   logic [NUM_LINES-1:0] drop_low;
   logic                 any_set;
   logic                 multi_set;

   // Clearing the lowest set bit leaves something only when 2+ bits are set
   assign drop_low  = lines & (lines - NUM_LINES'(1));
   assign any_set   = |lines;
   assign multi_set = |drop_low;

   always_comb begin
      if (multi_set)    cnt = LN_MANY;
      else if (any_set) cnt = LN_ONE;
      else              cnt = LN_NONE;
   end

   // One-hot to binary: index bit b is the OR of every line whose number has bit b set
   for (genvar b = 0; b < IDX_W; b++) begin : g_idx_bit
      logic [NUM_LINES-1:0] pick;
      for (genvar k = 0; k < NUM_LINES; k++) begin : g_pick
         if (((k >> b) & 1) == 1) begin : g_on
            assign pick[k] = lines[k];
         end else begin : g_off
            assign pick[k] = 1'b0;
         end
      end
      assign idx[b] = |pick;
   end

endmodule

// File: rtl/dtmf_tone_arbiter.sv
module dtmf_tone_arbiter
   import dtmf_kd_pkg::*;
(
   input  line_cnt_e row_cnt,
   input  line_cnt_e col_cnt,
   input  logic      dual_ok_n,
   output tone_req_t req
);

   logic dual_hit;
   logic row_single;
   logic col_single;

   assign dual_hit   = (row_cnt == LN_ONE) && (col_cnt == LN_ONE);
   // Several keys across one row
   assign row_single = (row_cnt == LN_ONE) && (col_cnt == LN_MANY);
   // Several keys down one column, or a lone column driven electronically
   assign col_single = (col_cnt == LN_ONE) &&
                       ((row_cnt == LN_MANY) || (row_cnt == LN_NONE));

   always_comb begin
      req.any_key = (row_cnt != LN_NONE) || (col_cnt != LN_NONE);
      req.row_en  = dual_hit || (row_single && dual_ok_n);
      req.col_en  = dual_hit || (col_single && dual_ok_n);
   end

endmodule

// File: rtl/dtmf_out_stage.sv
module dtmf_out_stage
   import dtmf_kd_pkg::*;
#(
   parameter int unsigned ROW_W = 2,
   parameter int unsigned COL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tone_req_t        req,
   input  logic [ROW_W-1:0] row_idx,
   input  logic [COL_W-1:0] col_idx,
   output logic             row_en,
   output logic             col_en,
   output logic [ROW_W-1:0] row_sel,
   output logic [COL_W-1:0] col_sel,
   output logic             mute,
   output logic             xmitr_oe
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_en   <= 1'b0;
         col_en   <= 1'b0;
         row_sel  <= '0;
         col_sel  <= '0;
         mute     <= 1'b0;
         xmitr_oe <= 1'b1;
      end else begin
         row_en   <= req.row_en;
         col_en   <= req.col_en;
         row_sel  <= req.row_en ? row_idx : '0;
         col_sel  <= req.col_en ? col_idx : '0;
         mute     <= req.any_key;
         xmitr_oe <= ~req.any_key;
      end
   end

endmodule

// File: rtl/dtmf_key_decode.sv
module dtmf_key_decode
   import dtmf_kd_pkg::*;
#(
   parameter int unsigned NUM_ROWS = 4,
   parameter int unsigned NUM_COLS = 4,
   localparam int unsigned ROW_W = $clog2(NUM_ROWS),
   localparam int unsigned COL_W = $clog2(NUM_COLS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_ROWS-1:0] row_act,
   input  logic [NUM_COLS-1:0] col_act,
   input  logic                dual_ok_n,
   output logic                row_en,
   output logic                col_en,
   output logic [ROW_W-1:0]    row_sel,
   output logic [COL_W-1:0]    col_sel,
   output logic                mute,
   output logic                xmitr_oe
);

   if (NUM_ROWS < 2) begin : g_bad_rows
      $error("dtmf_key_decode: NUM_ROWS must be at least 2");
   end
   if (NUM_COLS < 2) begin : g_bad_cols
      $error("dtmf_key_decode: NUM_COLS must be at least 2");
   end

   line_cnt_e        row_cnt;
   line_cnt_e        col_cnt;
   logic [ROW_W-1:0] row_idx;
   logic [COL_W-1:0] col_idx;
   tone_req_t        req;

   dtmf_line_scan #(.NUM_LINES(NUM_ROWS)) u_row_scan (
      .lines (row_act),
      .cnt   (row_cnt),
      .idx   (row_idx)
   );

   dtmf_line_scan #(.NUM_LINES(NUM_COLS)) u_col_scan (
      .lines (col_act),
      .cnt   (col_cnt),
      .idx   (col_idx)
   );

   dtmf_tone_arbiter u_arb (
      .row_cnt   (row_cnt),
      .col_cnt   (col_cnt),
      .dual_ok_n (dual_ok_n),
      .req       (req)
   );

   dtmf_out_stage #(.ROW_W(ROW_W), .COL_W(COL_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .row_idx  (row_idx),
      .col_idx  (col_idx),
      .row_en   (row_en),
      .col_en   (col_en),
      .row_sel  (row_sel),
      .col_sel  (col_sel),
      .mute     (mute),
      .xmitr_oe (xmitr_oe)
   );

endmodule

// File: rtl/dtmf_key_decode_chk.sv
module dtmf_key_decode_chk #(
   parameter int unsigned NUM_ROWS = 4,
   parameter int unsigned NUM_COLS = 4,
   localparam int unsigned ROW_W = $clog2(NUM_ROWS),
   localparam int unsigned COL_W = $clog2(NUM_COLS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_ROWS-1:0] row_act,
   input logic [NUM_COLS-1:0] col_act,
   input logic                dual_ok_n,
   input logic                row_en,
   input logic                col_en,
   input logic [ROW_W-1:0]    row_sel,
   input logic [COL_W-1:0]    col_sel,
   input logic                mute,
   input logic                xmitr_oe
);

   // R1: reset values seen while reset is held
   always @(negedge clk) begin
      if (!rst_n) begin
         p_reset_vals_r1: assert (!row_en && !col_en && !mute && xmitr_oe
                                  && row_sel == '0 && col_sel == '0)
            else $error("reset state wrong");
      end
   end

   p_dual_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(row_act) == 1 && $countones(col_act) == 1) |=> (row_en && col_en));

   p_diagonal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(row_act) >= 2 && $countones(col_act) >= 2) |=> (!row_en && !col_en));

   p_no_col_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (col_act == '0) |=> (!row_en && !col_en));

   p_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!dual_ok_n) |=> (row_en == col_en));

   p_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (mute == ($past(row_act) != '0 || $past(col_act) != '0)));

   p_xmitr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (xmitr_oe == ($past(row_act) == '0 && $past(col_act) == '0)));

   p_sel_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!row_en |-> row_sel == '0) and (!col_en |-> col_sel == '0));

endmodule

bind dtmf_key_decode dtmf_key_decode_chk #(
   .NUM_ROWS (NUM_ROWS),
   .NUM_COLS (NUM_COLS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .row_act   (row_act),
   .col_act   (col_act),
   .dual_ok_n (dual_ok_n),
   .row_en    (row_en),
   .col_en    (col_en),
   .row_sel   (row_sel),
   .col_sel   (col_sel),
   .mute      (mute),
   .xmitr_oe  (xmitr_oe)
);

// File: tb/tb_dtmf_key_decode.sv
`timescale 1ns/1ps
module tb_dtmf_key_decode;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] row_act = '0;
   logic [3:0] col_act = '0;
   logic       dual_ok_n = 1'b1;
   logic       row_en, col_en, mute, xmitr_oe;
   logic [1:0] row_sel, col_sel;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 0;

   // expected outputs for the vector captured at the next rising edge
   bit         pend = 0;
   bit         e_ren, e_cen, e_mute, e_xo;
   int         e_rsel, e_csel;
   string      e_tag;

   always #2.5 clk = ~clk;

   dtmf_key_decode dut (
      .clk(clk), .rst_n(rst_n), .row_act(row_act), .col_act(col_act),
      .dual_ok_n(dual_ok_n), .row_en(row_en), .col_en(col_en),
      .row_sel(row_sel), .col_sel(col_sel), .mute(mute), .xmitr_oe(xmitr_oe)
   );

   function automatic int pos_of(input logic [3:0] v);
      for (int i = 0; i < 4; i++) if (v[i]) return i;
      return 0;
   endfunction

   // Behavioural reference: counts of active lines decide the outcome
   task automatic model(input logic [3:0] r, input logic [3:0] c, input logic inh_n);
      int nr, nc;
      nr = $countones(r);
      nc = $countones(c);
      e_ren = 0; e_cen = 0;
      if (nr == 1 && nc == 1)      begin e_ren = 1; e_cen = 1; e_tag = "R2"; end
      else if (nr == 1 && nc >= 2) begin e_ren = inh_n; e_tag = inh_n ? "R3" : "R8"; end
      else if (nr >= 2 && nc == 1) begin e_cen = inh_n; e_tag = inh_n ? "R4" : "R8"; end
      else if (nr >= 2 && nc >= 2) e_tag = "R5";
      else if (nr == 0 && nc == 1) begin e_cen = inh_n; e_tag = inh_n ? "R6" : "R8"; end
      else if (nr == 0 && nc >= 2) e_tag = "R6";
      else                         e_tag = "R7";
      e_rsel = e_ren ? pos_of(r) : 0;
      e_csel = e_cen ? pos_of(c) : 0;
      e_mute = (nr + nc) > 0;
      e_xo   = !e_mute;
   endtask

   task automatic compare();
      string tag;
      n_chk++;
      if (row_en !== e_ren || col_en !== e_cen || row_sel !== 2'(e_rsel) ||
          col_sel !== 2'(e_csel) || mute !== e_mute || xmitr_oe !== e_xo) begin
         if (mute !== e_mute) tag = "R9";
         else if (xmitr_oe !== e_xo) tag = "R10";
         else if ((!e_ren && row_sel !== 2'd0) || (!e_cen && col_sel !== 2'd0)) tag = "R11";
         else tag = e_tag;
         n_bad++;
         $display("FAIL %s: got en=%b%b sel=%0d/%0d mute=%b oe=%b, expected en=%b%b sel=%0d/%0d mute=%b oe=%b",
                  tag, row_en, col_en, row_sel, col_sel, mute, xmitr_oe,
                  e_ren, e_cen, e_rsel, e_csel, e_mute, e_xo);
      end
   endtask

   // Drive on a falling edge, first checking the vector driven one cycle before
   task automatic apply(input logic [3:0] r, input logic [3:0] c, input logic inh_n);
      @(negedge clk);
      if (pend) compare();
      row_act = r; col_act = c; dual_ok_n = inh_n;
      model(r, c, inh_n);
      pend = 1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got %0d cycles, expected fewer than 20000", cycles);
         finish_run();
      end
   end

   initial begin
      // R1: reset holds outputs despite active lines
      row_act = 4'b0001; col_act = 4'b0001;
      repeat (3) @(negedge clk);
      n_chk++;
      if (row_en !== 0 || col_en !== 0 || row_sel !== 0 || col_sel !== 0 ||
          mute !== 0 || xmitr_oe !== 1) begin
         n_bad++;
         $display("FAIL R1: got en=%b%b sel=%0d/%0d mute=%b oe=%b, expected en=00 sel=0/0 mute=0 oe=1",
                  row_en, col_en, row_sel, col_sel, mute, xmitr_oe);
      end
      row_act = '0; col_act = '0;
      model('0, '0, 1'b1); pend = 1;
      rst_n = 1'b1;

      // Directed cases
      apply(4'b0100, 4'b0010, 1); // R2 row2 col1
      apply(4'b1000, 4'b1000, 1); // R2 row3 col3
      apply(4'b0010, 4'b1010, 1); // R3
      apply(4'b1101, 4'b0100, 1); // R4
      apply(4'b0011, 4'b0110, 1); // R5
      apply(4'b0000, 4'b1000, 1); // R6 single col
      apply(4'b0000, 4'b0101, 1); // R6 multi col
      apply(4'b0001, 4'b0000, 1); // R7
      apply(4'b0010, 4'b1010, 0); // R8 row-only suppressed
      apply(4'b0000, 4'b0100, 0); // R8 col-alone suppressed, R9 mute still high
      apply(4'b0001, 4'b0001, 0); // R8 dual still allowed
      apply(4'b0000, 4'b0000, 0); // R10 idle

      // R11: output must not move before the rising edge
      @(negedge clk);
      compare(); pend = 0;
      row_act = 4'b0001; col_act = 4'b0010; dual_ok_n = 1;
      #1;
      n_chk++;
      if (mute !== 1'b0) begin
         n_bad++;
         $display("FAIL R11: got mute=%b before edge, expected 0", mute);
      end
      model(4'b0001, 4'b0010, 1'b1); pend = 1;

      // Exhaustive sweep
      for (int inh = 0; inh < 2; inh++)
         for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++)
               apply(4'(r), 4'(c), 1'(inh));
      apply(4'b0000, 4'b0000, 1);
      @(negedge clk);
      compare();
      finish_run();
   end

endmodule